// File: doc/BRIEF.md
# Banked Work RAM Controller

This block serves the work RAM part of a 16-bit CPU address space. Every clock cycle the CPU presents one access: an address, write data and a write enable. One cycle later the block returns read data together with a hit flag. The hit flag says whether the address belonged to this block.

The window at 0xC000–0xCFFF is tied to physical bank 0. The window at 0xD000–0xDFFF follows a selectable bank. The range 0xE000–0xFDFF is a mirror that folds onto 0xC000 with the offset masked by 0x1FFF. Mirror accesses reach the same storage as the windows, so no second copy exists. A bank-select register sits at 0xFF70.

The `ext_mode` input chooses between two modes:
- Extended mode offers eight banks. It is used when the loaded program's compatibility byte is 0x80 or 0xC0.
- Legacy mode offers two fixed banks. In legacy mode the select register reads as all ones and ignores writes.

Each bank holds 2^`OFS_W` bytes and uses the low `OFS_W` address bits. A full 4 KiB bank uses `OFS_W` = 12. The default is kept small to bound the model's storage.

Top module: `wram_banker`

## Requirements
- R1: Addresses 0xC000–0xCFFF always reach physical bank 0, whatever bank is selected.
- R2: Addresses 0xD000–0xDFFF reach the effective bank. The storage index is bank × 2^OFS_W + (address mod 2^OFS_W).
- R3: In extended mode, a write to 0xFF70 selects the bank given by bits [2:0] of the write data, and a value of 0 selects bank 1. A read of 0xFF70 returns 0xF8 OR bank, so bits [7:3] read as ones.
- R4: After reset the selected bank is 1, so a first read of 0xFF70 in extended mode returns 0xF9.
- R5: In legacy mode (`ext_mode`=0):
  - a read of 0xFF70 returns 0xFF with hit set;
  - a write to 0xFF70 leaves the selected bank unchanged, which shows once extended mode returns;
  - 0xD000–0xDFFF uses bank 1.
- R6: An access to 0xE000–0xFDFF behaves exactly like an access to 0xC000 + ((address − 0xE000) AND 0x1FFF), for both reads and writes.
- R7: An address outside 0xC000–0xFDFF and other than 0xFF70 returns hit 0 and read data 0x00. A write to such an address alters no storage and no bank selection.
- R8: Read data and hit appear one clock after the access is presented. A write returns the content the location held before that write.
- R9: An access to 0xC000–0xFDFF or 0xFF70 returns hit 1 one clock later, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode | input | 1 | 1 = eight-bank extended mode, 0 = legacy mode |
| addr | input | 16 | CPU address of the current access |
| wdata | input | DATA_W | Write data |
| we | input | 1 | Write enable for the current access |
| rdata | output | DATA_W | Read data for the previous cycle's access |
| hit | output | 1 | The previous cycle's access decoded to this block |

## Verification
The main function is exercised with the following patterns:
- **Full fill.** Every bank is first filled with a pattern that differs per bank. A later upper-window read that lands in the wrong bank therefore shows up as a data mismatch, which separates bank-selection faults from addressing faults.
- **Bank cycling.** Reads of the lower window are interleaved with bank switches. Reads through both mirror halves reach the same locations. This separates the fixed bank from the switched bank and a correct fold from an offset-only fold.
- **Write followed by read.** Back-to-back write-then-read pairs distinguish read-before-write from write-first behaviour.
- **Mode changes.** Register writes in legacy mode, followed by a return to extended mode, show whether legacy writes leaked into the bank register.
- **Unmapped writes.** Writes just past the mirror, for example at 0xFE00, are followed by a read of the location they would have folded onto. This confirms that the mirror's end is enforced.

// File: rtl/wram_banker.sv
module wram_banker #(
  parameter int DATA_W    = 8,
  parameter int NUM_BANKS = 8,
  parameter int OFS_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_mode,
  input  logic [15:0]       addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  output logic [DATA_W-1:0] rdata,
  output logic              hit
);

  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int DEPTH  = NUM_BANKS << OFS_W;
  localparam int IDX_W  = BANK_W + OFS_W;
  localparam logic [15:0] SEL_ADDR = 16'hFF70;
  localparam logic [15:0] ECHO_LO  = 16'hE000;
  localparam logic [15:0] ECHO_HI  = 16'hFDFF;
  localparam logic [BANK_W-1:0] BANK_ONE = BANK_W'(1);

  logic [BANK_W-1:0] bank_q, eff_bank, ram_bank, wr_bank;
  logic              in_win, in_echo, in_ram, in_sel;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] mem_q, sel_rd_q;
  logic              ram_q, sel_q;

  // window decode; the mirror keeps address bit 12, so it picks lower/upper alike
  assign in_win   = (addr[15:13] == 3'b110);
  assign in_echo  = (addr >= ECHO_LO) && (addr <= ECHO_HI);
  assign in_ram   = in_win | in_echo;
  assign in_sel   = (addr == SEL_ADDR);
  assign eff_bank = ext_mode ? bank_q : BANK_ONE;
  assign ram_bank = addr[12] ? eff_bank : '0;
  assign idx      = {ram_bank, addr[OFS_W-1:0]};
  assign wr_bank  = (wdata[BANK_W-1:0] == '0) ? BANK_ONE : wdata[BANK_W-1:0];

  always_ff @(posedge clk) begin
    if (in_ram && we) mem[idx] <= wdata;
    mem_q <= mem[idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q   <= BANK_ONE;
      ram_q    <= 1'b0;
      sel_q    <= 1'b0;
      sel_rd_q <= '0;
    end else begin
      ram_q    <= in_ram;
      sel_q    <= in_sel;
      sel_rd_q <= ext_mode ? {{(DATA_W-BANK_W){1'b1}}, bank_q} : '1;
      if (in_sel && we && ext_mode) bank_q <= wr_bank;
    end
  end

  assign rdata = ram_q ? mem_q : (sel_q ? sel_rd_q : '0);
  assign hit   = ram_q | sel_q;

  a_r4_reset_bank: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> bank_q == BANK_ONE);

  a_r3_bank_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    bank_q != '0);

  a_r3_select_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && we && in_sel && wdata[BANK_W-1:0] != '0) |=> bank_q == $past(wdata[BANK_W-1:0]));

  a_r5_legacy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && we && in_sel) |=> $stable(bank_q));

  a_r7_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ram || in_sel) |=> (!hit && rdata == '0));

  a_r9_hit_claim: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ram || in_sel) |=> hit);

endmodule

// File: tb/wram_banker_tb.sv
module wram_banker_tb;
  localparam int OFS_W = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_mode = 1'b1;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  wdata = 8'h00;
  logic        we = 1'b0;
  logic [7:0]  rdata;
  logic        hit;

  wram_banker #(.DATA_W(8), .NUM_BANKS(8), .OFS_W(OFS_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .addr(addr),
    .wdata(wdata), .we(we), .rdata(rdata), .hit(hit));

  always #10 clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [7:0] m [0:2047];
  int  mbank = 1;
  bit  mext  = 1'b1;

  int unsigned q_cyc[$];
  bit          q_hit[$];
  logic [7:0]  q_dat[$];
  bit          q_chk[$];
  string       q_req[$];

  function automatic void look(input logic [15:0] a, output int kind, output int idx);
    int off, b;
    kind = 0; idx = 0;
    if (a >= 16'hC000 && a <= 16'hFDFF) begin
      off  = (a >= 16'hE000) ? ((int'(a) - 'hE000) & 'h1FFF) : (int'(a) - 'hC000);
      b    = (off >= 'h1000) ? (mext ? mbank : 1) : 0;
      idx  = b * (1 << OFS_W) + (off % (1 << OFS_W));
      kind = 1;
    end else if (a == 16'hFF70) kind = 2;
  endfunction

  task automatic acc(input logic [15:0] a, input logic [7:0] d, input bit w,
                     input string req, input bit chkd = 1'b1);
    int kind, idx;
    logic [7:0] ev;
    @(negedge clk);
    addr = a; wdata = d; we = w; ext_mode = mext;
    look(a, kind, idx);
    ev = (kind == 1) ? m[idx] : (kind == 2) ? (mext ? (8'hF8 | 8'(mbank)) : 8'hFF) : 8'h00;
    q_cyc.push_back(cyc); q_hit.push_back(kind != 0); q_dat.push_back(ev);
    q_chk.push_back(chkd); q_req.push_back(req);
    if (w) begin
      if (kind == 1) m[idx] = d;
      else if (kind == 2 && mext) mbank = ((d & 7) == 0) ? 1 : (d & 7);
    end
  endtask

  task automatic rd(input logic [15:0] a, input string req);
    acc(a, 8'h00, 1'b0, req);
  endtask

  always @(negedge clk) begin
    if (q_cyc.size() > 0 && q_cyc[0] + 1 == cyc) begin
      bit h; logic [7:0] dv; bit c; string r;
      h = q_hit.pop_front(); dv = q_dat.pop_front(); c = q_chk.pop_front();
      r = q_req.pop_front(); void'(q_cyc.pop_front());
      checks++;
      if (hit !== h || (c && rdata !== dv)) begin
        fails++;
        $display("FAIL %s: hit=%0b rdata=%02h expected hit=%0b rdata=%02h%s",
                 r, hit, rdata, h, dv, c ? "" : " (data unchecked)");
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(16'hFF70, "R4 reset bank reads F9");
    // fill every bank: R9 hit on each write, data unknown beforehand
    for (int o = 0; o < (1 << OFS_W); o++)
      acc(16'hC000 + 16'(o), 8'(o * 7 + 1), 1'b1, "R9 fill bank0", 1'b0);
    for (int b = 1; b < 8; b++) begin
      acc(16'hFF70, 8'(b), 1'b1, "R3 select for fill");
      for (int o = 0; o < (1 << OFS_W); o++)
        acc(16'hD000 + 16'(o), 8'(b * 37 + o * 7 + 1), 1'b1, "R9 fill upper", 1'b0);
    end
    // R2 / R1: cycle banks, lower window fixed
    for (int b = 7; b >= 1; b--) begin
      acc(16'hFF70, 8'(b), 1'b1, "R3 bank select");
      rd(16'hD010, "R2 upper window bank data");
      rd(16'hD0FF, "R2 upper window last offset");
      rd(16'hC010, "R1 lower window fixed bank0");
    end
    // R3 zero and high bits
    acc(16'hFF70, 8'h00, 1'b1, "R3 zero write");
    rd(16'hFF70, "R3 zero maps to bank1");
    rd(16'hD020, "R3 bank1 after zero");
    acc(16'hFF70, 8'h0D, 1'b1, "R3 high bits dropped");
    rd(16'hFF70, "R3 readback FD");
    rd(16'hD020, "R3 bank5 data");
    // R6 mirror
    rd(16'hE010, "R6 mirror lower read");
    rd(16'hF020, "R6 mirror upper read");
    rd(16'hFDFF, "R6 mirror last address");
    acc(16'hF0AA, 8'h5A, 1'b1, "R6 mirror write");
    rd(16'hD0AA, "R6 window sees mirror write");
    acc(16'hC033, 8'hC3, 1'b1, "R6 window write");
    rd(16'hE033, "R6 mirror sees window write");
    // R8 read-before-write and latency
    acc(16'hC040, 8'h11, 1'b1, "R8 write returns old");
    acc(16'hC040, 8'h22, 1'b1, "R8 second write returns first");
    rd(16'hC040, "R8 read after write");
    acc(16'hFF70, 8'h02, 1'b1, "R8 select write returns old bank");
    rd(16'hFF70, "R8 select readback");
    // R7 misses
    rd(16'h0000, "R7 miss low");
    rd(16'hBFFF, "R7 miss below window");
    rd(16'hFF71, "R7 miss next to select");
    acc(16'hFE00, 8'hEE, 1'b1, "R7 write past mirror");
    acc(16'hFF6F, 8'h07, 1'b1, "R7 write beside select");
    rd(16'hDE00, "R7 fold target unchanged");
    rd(16'hFF70, "R7 bank unchanged");
    // R5 legacy
    mext = 1'b0;
    rd(16'hFF70, "R5 legacy select reads FF");
    acc(16'hFF70, 8'h06, 1'b1, "R5 legacy write ignored");
    rd(16'hD020, "R5 legacy upper uses bank1");
    rd(16'hC020, "R1 legacy lower bank0");
    rd(16'hF020, "R6 legacy mirror upper");
    acc(16'hD050, 8'h99, 1'b1, "R5 legacy write bank1");
    mext = 1'b1;
    rd(16'hFF70, "R5 bank kept through legacy");
    acc(16'hFF70, 8'h01, 1'b1, "R3 select bank1");
    rd(16'hD050, "R5 legacy write landed in bank1");
    rd(16'h0000, "R7 idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule